// File: doc/BRIEF.md
# Data Breakpoint Match Unit

This block watches every load and store the core performs and holds a small bank of data breakpoints. Each breakpoint has a compare address, a per-bit address ignore mask, an optional address-space identifier (ASID), a data value with a per-byte ignore field, and a control word. The block checks each access against every enabled breakpoint in the same cycle. For each breakpoint it looks at the direction (load or store), the unmasked address bits, the ASID when asked to, and the data bytes that the access actually touches.

On a match the block sets that breakpoint's sticky hit bit. One cycle after the access it then raises a debug-exception request, a per-breakpoint trigger pulse, or both, as the control word selects. Each report therefore belongs to exactly the access that caused it. Software programs and inspects the bank through a 32-bit memory-mapped register port. The access port is a monitor stream with a valid qualifier only. The core never waits on this block, so there is no ready signal and no back-pressure. Every cycle with `acc_valid` high is compared, and no cycle is ever dropped.

Top module: `dbm_unit`

## Requirements
- R1: After reset all hit bits are 0 and `dbg_exc_req` and `trig_out` are low. The global control word at offset 0x000 reads bit 0 = 1 (data breakpoints present). The status word at 0x004 holds the breakpoint count (`NUM_BP`, 1 to 15) in bits 27:24 and the ASID-compare capability in bit 30.
- R2: Breakpoint n (0 to NUM_BP-1) sits at byte offset 0x100 + 0x20·n. Its words are: +0x00 compare address, +0x04 address ignore mask, +0x08 ASID, +0x0C control, +0x10 data value. Control bits are: 0 enable, 1 load-match, 2 store-match, 3 exception, 4 trigger, 5 use-ASID, 11:8 per-byte data ignore. All other control bits read 0.
- R3: A breakpoint matches only when it is enabled and the access direction is allowed: a load needs control bit 1, a store needs control bit 2. With both bits clear it never matches.
- R4: An address bit takes part in the compare only when its mask bit is 0. A mask bit of 1 makes that address bit don't-care.
- R5: When the capability is present and use-ASID is set, the access ASID must equal the stored ASID. Without the capability the ASID word reads 0, use-ASID reads 0, and the ASID is never compared.
- R6: Data byte i (bits 8i+7:8i) is compared only if byte-enable i is 1 and ignore bit i is 0. Bytes that are not accessed or are ignored never prevent a match.
- R7: Hit bits live in status bits NUM_BP-1:0. They are sticky and are cleared by writing 1. A new match in the same cycle as a clear wins, and the bit stays set.
- R8: For an access with `acc_valid` high in cycle t, the outputs are valid in cycle t+1. `dbg_exc_req` is high if any matching breakpoint has the exception bit set. `trig_out[n]` is high if breakpoint n matches and has the trigger bit set. Both are single-cycle pulses, and a cycle with `acc_valid` low produces nothing.
- R9: Writes to the slots of unimplemented breakpoints or to unmapped offsets change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_is_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Virtual address of the access |
| acc_asid | input | ASID_W | Address-space identifier of the access |
| acc_be | input | 4 | Byte lanes touched by the access |
| acc_data | input | 32 | Data value of the access |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| dbg_exc_req | output | 1 | Debug-exception request pulse |
| trig_out | output | NUM_BP | Per-breakpoint trigger pulses |

## Verification
The bench sweeps every control combination against both access directions. It walks every address bit with its mask bit set and clear. It crosses all byte-enable and byte-ignore patterns with a mismatch in each byte. A design that drops a lane term or swaps the load and store bits fails a specific entry of these sweeps. A second instance built without ASID support shares the bus; with it the bench shows that a mismatched ASID blocks a match only where the capability exists. It also checks that the ASID word and use-ASID bit of that instance read 0. The bench targets a clear that collides with a new match, stray writes to slots past the last breakpoint, pulses that linger a second cycle, and a valid-low cycle that still reports.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 32;
  localparam int LANES  = REG_W / 8;
  localparam int RA_W   = 12;

  localparam logic [RA_W-1:0] OFF_GCTRL = 12'h000;
  localparam logic [RA_W-1:0] OFF_STAT  = 12'h004;
  localparam logic [RA_W-1:0] BP_BASE   = 12'h100;
  localparam int              BP_SHIFT  = 5;
  localparam logic [RA_W-1:0] BP_SPAN   = 12'h200;
  localparam logic [4:0] SUB_ADDR = 5'h00;
  localparam logic [4:0] SUB_MASK = 5'h04;
  localparam logic [4:0] SUB_ASID = 5'h08;
  localparam logic [4:0] SUB_CTRL = 5'h0C;
  localparam logic [4:0] SUB_DATA = 5'h10;

  localparam int STAT_CNT_LSB = 24;
  localparam int STAT_ASID_CAP = 30;

  typedef struct packed {
    logic [LANES-1:0] ign;
    logic use_asid;
    logic trg;
    logic exc;
    logic st;
    logic ld;
    logic en;
  } bp_ctrl_t;

  function automatic bp_ctrl_t ctrl_unpack(input logic [REG_W-1:0] w, input bit asid_ok);
    bp_ctrl_t c;
    c.en       = w[0];
    c.ld       = w[1];
    c.st       = w[2];
    c.exc      = w[3];
    c.trg      = w[4];
    c.use_asid = w[5] & asid_ok;
    c.ign      = w[8 +: LANES];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctrl_pack(input bp_ctrl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[0] = c.en;
    w[1] = c.ld;
    w[2] = c.st;
    w[3] = c.exc;
    w[4] = c.trg;
    w[5] = c.use_asid;
    w[8 +: LANES] = c.ign;
    return w;
  endfunction
endpackage

// File: rtl/dbm_bp_cmp.sv
module dbm_bp_cmp
  import dbm_pkg::*;
#(
  parameter int ASID_W   = 8,
  parameter bit HAS_ASID = 1'b1
) (
  input  logic              acc_is_store,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ASID_W-1:0] acc_asid,
  input  logic [LANES-1:0]  acc_be,
  input  logic [REG_W-1:0]  acc_data,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic [ADDR_W-1:0] bp_mask,
  input  logic [ASID_W-1:0] bp_asid,
  input  logic [REG_W-1:0]  bp_data,
  input  bp_ctrl_t          bp_ctrl,
  output logic              match
);
  logic             dir_ok;
  logic             addr_ok;
  logic             asid_ok;
  logic [LANES-1:0] lane_ok;

  // Direction qualifier (R3)
  assign dir_ok  = acc_is_store ? bp_ctrl.st : bp_ctrl.ld;
  // Address compare with per-bit don't-care (R4)
  assign addr_ok = ((acc_addr ^ bp_addr) & ~bp_mask) == '0;

  // ASID compare present only with the capability (R5)
  generate
    if (HAS_ASID) begin : g_asid
      assign asid_ok = !bp_ctrl.use_asid || (acc_asid == bp_asid);
    end else begin : g_no_asid
      assign asid_ok = 1'b1;
    end
  endgenerate

  // Data compare per accessed, non-ignored byte (R6)
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_ok[l] = !acc_be[l] || bp_ctrl.ign[l] ||
                        (acc_data[8*l +: 8] == bp_data[8*l +: 8]);
  end

  assign match = bp_ctrl.en && dir_ok && addr_ok && asid_ok && (&lane_ok);
endmodule

// File: rtl/dbm_regs.sv
module dbm_regs
  import dbm_pkg::*;
#(
  parameter int NUM_BP   = 4,
  parameter int ASID_W   = 8,
  parameter bit HAS_ASID = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NUM_BP-1:0] hit_set,
  output logic [NUM_BP-1:0] hit_q,
  output logic [ADDR_W-1:0] cfg_addr [NUM_BP],
  output logic [ADDR_W-1:0] cfg_mask [NUM_BP],
  output logic [ASID_W-1:0] cfg_asid [NUM_BP],
  output logic [REG_W-1:0]  cfg_data [NUM_BP],
  output bp_ctrl_t          cfg_ctrl [NUM_BP]
);
  localparam logic [3:0] CNT = 4'(NUM_BP);

  logic [RA_W-1:0]   rel;
  logic              in_bp;
  logic [3:0]        slot;
  logic [4:0]        sub;
  logic [NUM_BP-1:0] clr;

  assign rel   = reg_addr - BP_BASE;
  assign in_bp = rel < BP_SPAN;
  assign slot  = rel[BP_SHIFT +: 4];
  assign sub   = rel[BP_SHIFT-1:0];

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
    logic sel;
    assign sel = reg_wen && in_bp && (slot == 4'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_addr[g] <= '0;
        cfg_mask[g] <= '0;
        cfg_data[g] <= '0;
        cfg_ctrl[g] <= '0;
      end else if (sel) begin
        case (sub)
          SUB_ADDR: cfg_addr[g] <= reg_wdata;
          SUB_MASK: cfg_mask[g] <= reg_wdata;
          SUB_DATA: cfg_data[g] <= reg_wdata;
          SUB_CTRL: cfg_ctrl[g] <= ctrl_unpack(reg_wdata, HAS_ASID);
          default: ;
        endcase
      end
    end

    if (HAS_ASID) begin : g_asid_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_asid[g] <= '0;
        else if (sel && sub == SUB_ASID) cfg_asid[g] <= reg_wdata[ASID_W-1:0];
      end
    end else begin : g_asid_none
      assign cfg_asid[g] = '0;
    end
  end

  // Sticky hits, write-1-to-clear, set wins (R7)
  assign clr = (reg_wen && reg_addr == OFF_STAT) ? reg_wdata[NUM_BP-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= '0;
    else        hit_q <= (hit_q & ~clr) | hit_set;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFF_GCTRL) begin
      reg_rdata[0] = 1'b1;
    end else if (reg_addr == OFF_STAT) begin
      reg_rdata[NUM_BP-1:0]          = hit_q;
      reg_rdata[STAT_CNT_LSB +: 4]   = CNT;
      reg_rdata[STAT_ASID_CAP]       = HAS_ASID;
    end else if (in_bp) begin
      for (int k = 0; k < NUM_BP; k++) begin
        if (slot == 4'(k)) begin
          case (sub)
            SUB_ADDR: reg_rdata = cfg_addr[k];
            SUB_MASK: reg_rdata = cfg_mask[k];
            SUB_ASID: reg_rdata[ASID_W-1:0] = cfg_asid[k];
            SUB_CTRL: reg_rdata = ctrl_pack(cfg_ctrl[k]);
            SUB_DATA: reg_rdata = cfg_data[k];
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_BP; g++) begin : g_chk
    a_r7_hit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q[g] && !clr[g] |=> hit_q[g]);
    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      clr[g] && !hit_set[g] |=> !hit_q[g]);
  end
endmodule

// File: rtl/dbm_unit.sv
module dbm_unit
  import dbm_pkg::*;
#(
  parameter int NUM_BP   = 4,
  parameter int ASID_W   = 8,
  parameter bit HAS_ASID = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_is_store,
  input  logic [31:0]       acc_addr,
  input  logic [ASID_W-1:0] acc_asid,
  input  logic [3:0]        acc_be,
  input  logic [31:0]       acc_data,
  input  logic              reg_wen,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              dbg_exc_req,
  output logic [NUM_BP-1:0] trig_out
);
  logic [ADDR_W-1:0] cfg_addr [NUM_BP];
  logic [ADDR_W-1:0] cfg_mask [NUM_BP];
  logic [ASID_W-1:0] cfg_asid [NUM_BP];
  logic [REG_W-1:0]  cfg_data [NUM_BP];
  bp_ctrl_t          cfg_ctrl [NUM_BP];
  logic [NUM_BP-1:0] match;
  logic [NUM_BP-1:0] hit_now;
  logic [NUM_BP-1:0] exc_sel;
  logic [NUM_BP-1:0] trg_sel;
  logic [NUM_BP-1:0] hit_q;

  dbm_regs #(.NUM_BP(NUM_BP), .ASID_W(ASID_W), .HAS_ASID(HAS_ASID)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hit_set(hit_now), .hit_q(hit_q),
    .cfg_addr(cfg_addr), .cfg_mask(cfg_mask), .cfg_asid(cfg_asid),
    .cfg_data(cfg_data), .cfg_ctrl(cfg_ctrl)
  );

  for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
    dbm_bp_cmp #(.ASID_W(ASID_W), .HAS_ASID(HAS_ASID)) u_cmp (
      .acc_is_store(acc_is_store), .acc_addr(acc_addr), .acc_asid(acc_asid),
      .acc_be(acc_be), .acc_data(acc_data),
      .bp_addr(cfg_addr[g]), .bp_mask(cfg_mask[g]), .bp_asid(cfg_asid[g]),
      .bp_data(cfg_data[g]), .bp_ctrl(cfg_ctrl[g]),
      .match(match[g])
    );
    assign exc_sel[g] = cfg_ctrl[g].exc;
    assign trg_sel[g] = cfg_ctrl[g].trg;
  end

  assign hit_now = acc_valid ? match : '0;

  // Precise one-cycle reports (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_exc_req <= 1'b0;
      trig_out    <= '0;
    end else begin
      dbg_exc_req <= |(hit_now & exc_sel);
      trig_out    <= hit_now & trg_sel;
    end
  end

  a_r8_exc_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exc_req |-> $past(acc_valid));

  for (genvar g = 0; g < NUM_BP; g++) begin : g_out_chk
    a_r7_trig_marks_hit: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out[g] |-> hit_q[g]);
    a_r3_trig_direction: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out[g] |-> $past(acc_is_store ? cfg_ctrl[g].st : cfg_ctrl[g].ld));
    a_r8_trig_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out[g] |-> $past(acc_valid));
  end
endmodule

// File: tb/test_dbm_unit.sv
module test_dbm_unit;
  localparam int CLK_P = 10;
  localparam logic [11:0] A_GCTRL = 12'h000;
  localparam logic [11:0] A_STAT  = 12'h004;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_is_store = 1'b0;
  logic [31:0] acc_addr = '0, acc_data = '0;
  logic [7:0]  acc_asid = '0;
  logic [3:0]  acc_be = '0;
  logic reg_wen = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic exc_a, exc_b;
  logic [3:0] trg_a;
  logic [0:0] trg_b;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_P/2) clk = ~clk;

  dbm_unit #(.NUM_BP(4), .ASID_W(8), .HAS_ASID(1'b1)) i_dbm_unit (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_is_store(acc_is_store),
    .acc_addr(acc_addr), .acc_asid(acc_asid), .acc_be(acc_be), .acc_data(acc_data),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_a),
    .dbg_exc_req(exc_a), .trig_out(trg_a));

  dbm_unit #(.NUM_BP(1), .ASID_W(8), .HAS_ASID(1'b0)) i_dbm_unit_b (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_is_store(acc_is_store),
    .acc_addr(acc_addr), .acc_asid(acc_asid), .acc_be(acc_be), .acc_data(acc_data),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_b),
    .dbg_exc_req(exc_b), .trig_out(trg_b));

  function automatic logic [11:0] bpa(input int n, input logic [4:0] off);
    return 12'h100 + 12'(n * 32) + 12'(off);
  endfunction

  // Expected match from the requirement text
  function automatic bit model(input logic [31:0] c, input logic [31:0] ba, input logic [31:0] bm,
                               input logic [7:0] bas, input logic [31:0] bd, input bit cap,
                               input bit st, input logic [31:0] a, input logic [7:0] as,
                               input logic [3:0] be, input logic [31:0] d);
    bit ok;
    ok = c[0] && (st ? c[2] : c[1]);
    ok = ok && (((a ^ ba) & ~bm) == 32'h0);
    if (cap && c[5]) ok = ok && (as == bas);
    for (int i = 0; i < 4; i++)
      if (be[i] && !c[8+i] && (a[0] | 1'b1) && d[8*i +: 8] != bd[8*i +: 8]) ok = 1'b0;
    return ok;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    reg_addr = a;
    #1;
  endtask

  task automatic cfg(input int n, input logic [31:0] a, input logic [31:0] m,
                     input logic [7:0] as, input logic [31:0] d, input logic [31:0] c);
    wr(bpa(n, 5'h00), a);
    wr(bpa(n, 5'h04), m);
    wr(bpa(n, 5'h08), {24'h0, as});
    wr(bpa(n, 5'h10), d);
    wr(bpa(n, 5'h0C), c);
  endtask

  logic s_exc_a, s_exc_b, late;
  logic [3:0] s_trg_a;
  logic s_trg_b;

  task automatic acc(input bit v, input bit st, input logic [31:0] a, input logic [7:0] as,
                     input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    acc_valid = v; acc_is_store = st; acc_addr = a; acc_asid = as; acc_be = be; acc_data = d;
    @(posedge clk);
    #1;
    s_exc_a = exc_a; s_trg_a = trg_a; s_exc_b = exc_b; s_trg_b = trg_b[0];
    @(negedge clk);
    acc_valid = 1'b0;
    @(posedge clk);
    #1;
    late = exc_a | (|trg_a) | exc_b | trg_b[0];
  endtask

  initial begin
    #(CLK_P * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] c;
    bit e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_GCTRL);
    chk("R1 presence bit", rd_a, 32'h1);
    rd(A_STAT);
    chk("R1 status A", rd_a, (32'd4 << 24) | (32'd1 << 30));
    chk("R1 status B", rd_b, (32'd1 << 24));
    chk("R1 outputs idle", {27'h0, exc_a, trg_a}, 32'h0);

    // R2 register readback and control field layout
    cfg(2, 32'hCAFE_0010, 32'h0000_00F0, 8'h5A, 32'hDEAD_BEEF, 32'hFFFF_FFFF);
    rd(bpa(2, 5'h00)); chk("R2 addr", rd_a, 32'hCAFE_0010);
    rd(bpa(2, 5'h04)); chk("R2 mask", rd_a, 32'h0000_00F0);
    rd(bpa(2, 5'h08)); chk("R2 asid", rd_a, 32'h5A);
    rd(bpa(2, 5'h0C)); chk("R2 ctrl", rd_a, 32'h0000_0F3F);
    rd(bpa(2, 5'h10)); chk("R2 data", rd_a, 32'hDEAD_BEEF);
    cfg(2, 0, 0, 0, 0, 0);

    // R5 capability absent: ASID word and use-ASID bit read zero
    wr(bpa(0, 5'h08), 32'h55);
    wr(bpa(0, 5'h0C), 32'hFFFF);
    rd(bpa(0, 5'h08)); chk("R5 no-cap asid reads 0", rd_b, 32'h0);
    rd(bpa(0, 5'h0C)); chk("R5 no-cap use-asid reads 0", rd_b, 32'h0F1F);

    // R9 unimplemented slots
    wr(bpa(4, 5'h00), 32'h1234_5678);
    rd(bpa(4, 5'h00)); chk("R9 slot 4 reads 0", rd_a, 32'h0);
    wr(bpa(15, 5'h10), 32'hFFFF_FFFF);
    rd(bpa(15, 5'h10)); chk("R9 slot 15 reads 0", rd_a, 32'h0);
    wr(12'h3F0, 32'hFFFF_FFFF);
    rd(12'h3F0); chk("R9 unmapped reads 0", rd_a, 32'h0);
    wr(bpa(1, 5'h00), 32'hABCD_0000);
    rd(bpa(1, 5'h00));
    chk("R9 B slot 1 reads 0", rd_b, 32'h0);
    chk("R2 A slot 1 kept", rd_a, 32'hABCD_0000);
    wr(bpa(1, 5'h00), 0);
    rd(A_STAT); chk("R9 no stray hit", rd_a & 32'hF, 32'h0);

    // R3 sweep over enable/load/store against both directions
    cfg(0, 32'h0000_1000, 0, 0, 0, 32'h0F18);
    for (int k = 0; k < 8; k++) begin
      for (int s = 0; s < 2; s++) begin
        c = 32'h0F18 | 32'(k);
        wr(bpa(0, 5'h0C), c);
        wr(A_STAT, 32'hF);
        acc(1'b1, s[0], 32'h0000_1000, 0, 4'hF, 32'h0);
        e = model(c, 32'h1000, 0, 0, 0, 1'b1, s[0], 32'h1000, 0, 4'hF, 0);
        chk("R3 trigger", {31'h0, s_trg_a[0]}, {31'h0, e});
        rd(A_STAT);
        chk("R3 hit bit", rd_a & 32'h1, {31'h0, e});
      end
    end

    // R4 walk every address bit with mask set and clear
    wr(bpa(0, 5'h0C), 32'h0F17);
    for (int b = 0; b < 32; b++) begin
      for (int m = 0; m < 2; m++) begin
        wr(bpa(0, 5'h04), m ? (32'h1 << b) : 32'h0);
        acc(1'b1, 1'b0, 32'h0000_1000 ^ (32'h1 << b), 0, 4'hF, 32'h0);
        chk("R4 masked address", {31'h0, s_trg_a[0]}, {31'h0, m[0]});
      end
    end
    wr(bpa(0, 5'h04), 32'hFFFF_FFFF);
    acc(1'b1, 1'b1, 32'h7654_3210, 0, 4'hF, 32'h0);
    chk("R4 full mask", {31'h0, s_trg_a[0]}, 32'h1);
    wr(bpa(0, 5'h04), 32'h0);

    // R6 byte-enable x ignore x differing byte
    wr(bpa(0, 5'h10), 32'h1122_3344);
    for (int d = 0; d < 4; d++) begin
      for (int ig = 0; ig < 16; ig++) begin
        c = 32'h17 | (32'(ig) << 8);
        wr(bpa(0, 5'h0C), c);
        for (int be = 0; be < 16; be++) begin
          acc(1'b1, 1'b0, 32'h1000, 0, 4'(be), 32'h1122_3344 ^ (32'hFF << (8*d)));
          e = !(be[d] && !ig[d]);
          chk("R6 data lanes", {31'h0, s_trg_a[0]}, {31'h0, e});
        end
      end
    end

    // R5 ASID qualification, with and without capability
    cfg(0, 32'h2000, 0, 8'h21, 0, 32'h0F37);
    acc(1'b1, 1'b0, 32'h2000, 8'h21, 4'hF, 0);
    chk("R5 asid equal A", {31'h0, s_trg_a[0]}, 32'h1);
    chk("R5 asid equal B", {31'h0, s_trg_b}, 32'h1);
    acc(1'b1, 1'b0, 32'h2000, 8'h22, 4'hF, 0);
    chk("R5 asid differ A", {31'h0, s_trg_a[0]}, 32'h0);
    chk("R5 asid ignored B", {31'h0, s_trg_b}, 32'h1);
    wr(bpa(0, 5'h0C), 32'h0F17);
    acc(1'b1, 1'b0, 32'h2000, 8'h22, 4'hF, 0);
    chk("R5 use-asid off A", {31'h0, s_trg_a[0]}, 32'h1);
    wr(bpa(0, 5'h0C), 32'h0);

    // R8 exception/trigger selection and pulse shape
    cfg(1, 32'h3000, 0, 0, 0, 32'h0F0F);
    cfg(2, 32'h3000, 0, 0, 0, 32'h0F17);
    acc(1'b1, 1'b1, 32'h3000, 0, 4'hF, 0);
    chk("R8 exception request", {31'h0, s_exc_a}, 32'h1);
    chk("R8 trigger select", {28'h0, s_trg_a}, 32'h4);
    chk("R8 single-cycle pulse", {31'h0, late}, 32'h0);
    wr(A_STAT, 32'hF);
    acc(1'b0, 1'b1, 32'h3000, 0, 4'hF, 0);
    chk("R8 invalid cycle silent", {27'h0, s_exc_a, s_trg_a}, 32'h0);
    rd(A_STAT); chk("R8 invalid cycle no hit", rd_a & 32'hF, 32'h0);
    wr(bpa(1, 5'h0C), 32'h0F07);
    acc(1'b1, 1'b1, 32'h3000, 0, 4'hF, 0);
    chk("R8 exception off", {31'h0, s_exc_a}, 32'h0);

    // R7 sticky hits, W1C, set wins
    rd(A_STAT); chk("R7 hits after match", rd_a & 32'hF, 32'h6);
    acc(1'b1, 1'b1, 32'h4000, 0, 4'hF, 0);
    rd(A_STAT); chk("R7 sticky on miss", rd_a & 32'hF, 32'h6);
    wr(A_STAT, 32'h9);
    rd(A_STAT); chk("R7 clear other bits", rd_a & 32'hF, 32'h6);
    wr(A_STAT, 32'h2);
    rd(A_STAT); chk("R7 clear own bit", rd_a & 32'hF, 32'h4);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = A_STAT; reg_wdata = 32'hF;
    acc_valid = 1'b1; acc_is_store = 1'b1; acc_addr = 32'h3000; acc_be = 4'hF; acc_data = 0;
    @(negedge clk);
    reg_wen = 1'b0; acc_valid = 1'b0;
    rd(A_STAT); chk("R7 set wins over clear", rd_a & 32'hF, 32'h6);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule